// File: doc/BRIEF.md
# Two-Beat Registered Stream Slice

This block sits on a valid/ready stream channel (AXI4-Stream style) and cuts every timing path through it in both directions. The data path, the output valid and the upstream ready all come from flip-flops. Nothing combinational runs from the downstream ready input to any output. Even so, the channel can move one beat per clock without pause.

The slice holds at most two beats: a primary output register and one spare ("skid") register. Upstream ready is high exactly when the spare register is empty. When the consumer stalls, the beat the producer pushed in that same cycle goes into the spare register, so it is not lost. When the consumer next takes a beat while both registers are full, the spare beat moves forward and upstream ready comes back one cycle later. The payload is a parameterised data word plus an end-of-packet flag, and the flag travels with its word.

Top module: `axis_skid_slice`

## Requirements
- R1: A synchronous active-high reset empties the slice: on the first cycle after reset, m_tvalid is 0 and s_tready is 1.
- R2: When s_tvalid and m_tready stay high, one beat leaves per clock after a single cycle of latency. Over N such cycles starting empty, N-1 beats are delivered.
- R3: A beat accepted (s_tvalid and s_tready high at a clock edge) while the output holds an unaccepted beat (m_tvalid high, m_tready low) is kept. s_tready is 0 on the next cycle.
- R4: s_tready is 0 exactly when two beats are held, and m_tvalid is then 1. s_tready does not change within a cycle in response to m_tready.
- R5: While m_tvalid is 1 and m_tready is 0, on the next cycle m_tvalid is still 1 and m_tdata and m_tlast are unchanged.
- R6: When two beats are held and the output beat is taken, the held spare beat appears on m_tdata in the next cycle, and s_tready is 1 in that cycle.
- R7: Beats leave in the order they were accepted, each exactly once, with no loss.
- R8: s_tvalid, s_tdata and s_tlast have no effect while s_tready is 0. Such a beat never appears at the output.
- R9: m_tlast is the s_tlast value accepted together with the same data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Producer offers a beat |
| s_tready | output | 1 | Slice can take a beat (spare register empty) |
| s_tdata | input | DATA_W | Producer data word |
| s_tlast | input | 1 | Producer end-of-packet flag |
| m_tvalid | output | 1 | Slice offers a beat |
| m_tready | input | 1 | Consumer takes the offered beat |
| m_tdata | output | DATA_W | Output data word |
| m_tlast | output | 1 | Output end-of-packet flag |

## Verification
A wrong occupancy state shows at the ports on the next clock edge. A slice that thinks it is full when it holds one beat drops s_tready one cycle too early. One that thinks it holds a beat when it is empty raises m_tvalid with a stale word. A mis-steered load shows up as a duplicated, reordered or missing word on the very next delivery. The bench therefore keeps its own occupancy count and queue of accepted beats. Every cycle it compares s_tready and m_tvalid with that count, and it compares each delivered word and flag with the head of the queue, so the fault is reported in the first cycle it becomes visible.

// File: rtl/skid_pkg.sv
package skid_pkg;

    // Number of beats currently held by the slice.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_e;

    // Occupancy after one clock, given an accept (in) and a delivery (out).
    function automatic occ_e occ_next(occ_e cur, logic acc, logic dlv);
        occ_e nxt;
        nxt = cur;
        unique case (cur)
            OCC_EMPTY: if (acc)         nxt = OCC_ONE;
            OCC_ONE:   if (acc && !dlv) nxt = OCC_TWO;
                       else if (!acc && dlv) nxt = OCC_EMPTY;
            OCC_TWO:   if (dlv)         nxt = OCC_ONE;
            default:                    nxt = OCC_EMPTY;
        endcase
        return nxt;
    endfunction

    // Upstream may push only while the spare register is free.
    function automatic logic has_room(occ_e occ);
        return occ != OCC_TWO;
    endfunction

    function automatic logic has_beat(occ_e occ);
        return occ != OCC_EMPTY;
    endfunction

endpackage

// File: rtl/skid_ctrl.sv
module skid_ctrl
    import skid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic up_valid,
    input  logic dn_ready,
    output logic up_ready,
    output logic dn_valid,
    output logic load_out_from_in,
    output logic load_out_from_spare,
    output logic load_spare
);

    occ_e occ_q;
    occ_e occ_d;
    logic ready_q;
    logic valid_q;
    logic acc;
    logic dlv;

    assign acc = up_valid & ready_q;
    assign dlv = valid_q & dn_ready;

    always_comb begin
        occ_d = occ_next(occ_q, acc, dlv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q   <= OCC_EMPTY;
            ready_q <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            occ_q   <= occ_d;
            ready_q <= has_room(occ_d);
            valid_q <= has_beat(occ_d);
        end
    end

    // Steering of the two storage registers.
    assign load_out_from_in    = acc & ((occ_q == OCC_EMPTY) | ((occ_q == OCC_ONE) & dlv));
    assign load_spare          = acc & (occ_q == OCC_ONE) & ~dlv;
    assign load_out_from_spare = dlv & (occ_q == OCC_TWO);

    assign up_ready = ready_q;
    assign dn_valid = valid_q;

    // R7: at most one load source per clock, so no beat is written twice.
    p_single_load_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_out_from_in, load_out_from_spare, load_spare}));

    // R4: a full slice never accepts.
    p_no_accept_full_r4: assert property (@(posedge clk) disable iff (rst)
        (occ_q == OCC_TWO) |-> !acc);

endmodule

// File: rtl/skid_store.sv
module skid_store #(
    parameter int PAYLOAD_W = 9
) (
    input  logic                 clk,
    input  logic [PAYLOAD_W-1:0] in_beat,
    input  logic                 load_out_from_in,
    input  logic                 load_out_from_spare,
    input  logic                 load_spare,
    output logic [PAYLOAD_W-1:0] out_beat
);

    logic [PAYLOAD_W-1:0] out_q;
    logic [PAYLOAD_W-1:0] spare_q;

    // Payload registers carry no reset; the valid flags qualify them.
    always_ff @(posedge clk) begin
        if (load_out_from_in)
            out_q <= in_beat;
        else if (load_out_from_spare)
            out_q <= spare_q;
    end

    always_ff @(posedge clk) begin
        if (load_spare)
            spare_q <= in_beat;
    end

    assign out_beat = out_q;

endmodule

// File: rtl/axis_skid_slice.sv
module axis_skid_slice #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast
);

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    beat_t in_beat;
    beat_t out_beat;
    logic  ld_in;
    logic  ld_spare_fwd;
    logic  ld_spare;

    assign in_beat.last = s_tlast;
    assign in_beat.data = s_tdata;

    skid_ctrl u_ctrl (
        .clk                 (clk),
        .rst                 (rst),
        .up_valid            (s_tvalid),
        .dn_ready            (m_tready),
        .up_ready            (s_tready),
        .dn_valid            (m_tvalid),
        .load_out_from_in    (ld_in),
        .load_out_from_spare (ld_spare_fwd),
        .load_spare          (ld_spare)
    );

    skid_store #(.PAYLOAD_W(BEAT_W)) u_store (
        .clk                 (clk),
        .in_beat             (in_beat),
        .load_out_from_in    (ld_in),
        .load_out_from_spare (ld_spare_fwd),
        .load_spare          (ld_spare),
        .out_beat            (out_beat)
    );

    assign m_tdata = out_beat.data;
    assign m_tlast = out_beat.last;

    // R5: an offered beat holds until taken.
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R3: accepting into a stalled output fills the spare and closes the input.
    p_stall_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && m_tvalid && !m_tready) |=> (!s_tready && m_tvalid));

    // R6: draining a full slice reopens the input next cycle.
    p_reopen_r6: assert property (@(posedge clk) disable iff (rst)
        (!s_tready && m_tready) |=> (s_tready && m_tvalid));

    // R4: input closed only while output holds a beat.
    p_full_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !s_tready |-> m_tvalid);

    // R2: an accepted beat is offered on the next cycle.
    p_accept_offer_r2: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> m_tvalid);

endmodule

// File: tb/axis_skid_slice_bench.sv
module axis_skid_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NVEC = 14;
    // Each entry: {s_tvalid, m_tready, cycle count}
    localparam logic [9:0] VECS [NVEC] = '{
        {1'b1, 1'b1, 8'd12},
        {1'b1, 1'b0, 8'd4},
        {1'b0, 1'b1, 8'd3},
        {1'b1, 1'b0, 8'd1},
        {1'b1, 1'b1, 8'd6},
        {1'b0, 1'b0, 8'd2},
        {1'b1, 1'b0, 8'd3},
        {1'b0, 1'b1, 8'd1},
        {1'b1, 1'b1, 8'd5},
        {1'b0, 1'b1, 8'd4},
        {1'b1, 1'b0, 8'd2},
        {1'b1, 1'b1, 8'd1},
        {1'b1, 1'b0, 8'd2},
        {1'b0, 1'b1, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tlast = 1'b0;
    logic          m_tvalid;
    logic          m_tready = 1'b0;
    logic [DW-1:0] m_tdata;
    logic          m_tlast;

    int checks = 0;
    int fails = 0;
    int held = 0;
    int delivered = 0;
    logic [DW-1:0] next_word = 16'h0100;
    logic [DW:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    axis_skid_slice #(.DATA_W(DW)) u_axis_skid_slice (
        .clk(clk), .rst(rst),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check, update the model, advance.
    task automatic step(input logic v, input logic r);
        logic [DW:0] head;
        s_tvalid = v;
        m_tready = r;
        s_tdata  = v ? next_word : 16'hDEAD;
        s_tlast  = v ? (next_word[1:0] == 2'b11) : 1'b1;
        #1;
        check(s_tready == (held < 2), "R4 s_tready", s_tready, held < 2);
        check(m_tvalid == (held > 0), "R5 m_tvalid", m_tvalid, held > 0);
        if (m_tvalid && m_tready) begin
            head = (q.size() > 0) ? q.pop_front() : '1;
            check({m_tlast, m_tdata} == head, "R7/R9 order and flag", {m_tlast, m_tdata}, head);
            held--;
            delivered++;
        end
        if (v && s_tready) begin
            q.push_back({s_tlast, s_tdata});
            next_word = next_word + 1'b1;
            held++;
        end
        // A beat offered while closed is not queued (R8); any leak fails the order check.
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        s_tvalid = 1'b0;
        m_tready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        held = 0;
        #1;
        check(m_tvalid == 1'b0, "R1 m_tvalid after reset", m_tvalid, 0);
        check(s_tready == 1'b1, "R1 s_tready after reset", s_tready, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        @(negedge clk);
        do_reset();

        // Table-driven sweep of valid/ready patterns.
        foreach (VECS[i]) begin
            for (int k = 0; k < int'(VECS[i][7:0]); k++)
                step(VECS[i][9], VECS[i][8]);
        end

        // R2: full-rate streaming from empty.
        do_reset();
        base = delivered;
        for (int k = 0; k < 30; k++) step(1'b1, 1'b1);
        check(delivered - base == 29, "R2 throughput", delivered - base, 29);

        // R3: stall with a beat in flight.
        do_reset();
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        check(s_tready == 1'b0, "R3 spare capture closes input", s_tready, 0);
        check(held == 2, "R3 two beats held", held, 2);

        // R4: s_tready does not follow m_tready within the cycle.
        m_tready = 1'b1;
        #1;
        check(s_tready == 1'b0, "R4 registered ready", s_tready, 0);

        // R8: offer a beat while closed, then R6: drain one.
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(s_tready == 1'b1, "R6 input reopens", s_tready, 1);
        check(m_tvalid == 1'b1, "R6 spare beat offered", m_tvalid, 1);
        check(m_tdata == q[0][DW-1:0], "R6 spare beat data", m_tdata, q[0][DW-1:0]);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1);
        check(q.size() == 0, "R7 no loss after drain", q.size(), 0);

        // R1: reset while full.
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        do_reset();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule